// File: doc/BRIEF.md
# Self-Timed Byte-Write EEPROM Emulator

This block is a synthesizable device-side stand-in for a 2K x 8 parallel EEPROM. All of its pins are sampled on a system clock. Chip-enable, output-enable and write-enable are decoded into read and write strobes. Bytes live in an internal array. Each accepted byte write runs for a fixed number of clock cycles with no further host involvement. While that write runs, any read returns a polling pattern instead of stored data.

The emulator also models several conditions of the real part:
- A supply-good flag and a power-on write lockout.
- A chip-clear operation, entered through an output-enable high-voltage flag, that fills the main array with 0xFF.
- A separate 32-byte identification area, selected by an address-bit-9 high-voltage flag.

The data output comes with an enable, so the surrounding logic can drive a tri-state bus. A busy indicator is brought out for test.

The controller is a state machine with six states:
- `ST_LOCK`: power-on hold.
- `ST_IDLE`
- `ST_STROBE`: write strobe open.
- `ST_PROG`: self-timed write.
- `ST_CLR_PULSE`: measuring the clear pulse.
- `ST_CLR_SWEEP`: filling the array.

The transitions are:
- Reset enters `ST_LOCK`.
- `ST_LOCK` goes to `ST_IDLE` after POR_CYC consecutive cycles of supply good.
- `ST_IDLE` goes to `ST_STROBE` when a write strobe opens.
- `ST_IDLE` goes to `ST_CLR_PULSE` when a clear strobe opens.
- `ST_STROBE` goes to `ST_PROG` when chip-enable or write-enable closes the strobe.
- `ST_STROBE` goes to `ST_IDLE` when output-enable closes it (abort).
- `ST_PROG` goes to `ST_IDLE` after WRITE_CYC cycles.
- `ST_CLR_PULSE` goes to `ST_CLR_SWEEP` when a pulse of at least CLEAR_CYC cycles is released.
- `ST_CLR_PULSE` goes to `ST_IDLE` when a shorter pulse is released.
- `ST_CLR_SWEEP` goes to `ST_IDLE` after the last address is filled.
- From any state, a low supply-good flag forces `ST_LOCK`.

Top module: `eeprom_emu`

## Requirements
- R1: `dout_oe` is 1 exactly when, two clock edges earlier, `ce_n`=0, `oe_n`=0, `we_n`=1 and `oe_hv`=0 were sampled. `dout` is 0 whenever `dout_oe` is 0.
- R2: A write strobe is open while `ce_n`=0, `we_n`=0, `oe_n`=1 and `oe_hv`=0. The address and `a9_hv` are captured in the first sampled cycle of the strobe. The data stored is the last `din` value sampled while the strobe was open.
- R3: The write is accepted when the strobe closes because `ce_n` or `we_n` rose. `busy` is then 1 for exactly WRITE_CYC cycles, after which a read returns the new byte.
- R4: While `busy` is 1 after a byte write, a read of any address returns the written byte with bit 7 inverted and bits 6..0 unchanged.
- R5: Write strobes that open while `busy` is 1 are ignored.
- R6: A strobe that `oe_n`=0 ends is aborted and stores nothing. With `oe_n`=0, `ce_n` and `we_n` low never start a write.
- R7: While `supply_ok`=0, writes are ignored. After `supply_ok` rises, writes stay ignored for POR_CYC cycles. Reads work throughout.
- R8: With `ce_n`=0 and `oe_hv`=1, a `we_n` low pulse of at least CLEAR_CYC sampled cycles sets every main-array byte to 0xFF once it is released. `busy` is 1 during the fill, and reads during the fill return 0x7F. A shorter pulse changes nothing.
- R9: With `a9_hv`=1, addresses 0x7E0..0x7FF (all of bits 10..5 set) read and write a separate 32-byte identification memory. Without the flag, those addresses reach the main array. Chip clear leaves the identification memory untouched.
- R10: After reset, `dout_oe`=0 and `busy`=0, and the block is in power-on lockout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_hv | input | 1 | Output-enable pin held at high voltage (chip clear) |
| a9_hv | input | 1 | Address bit 9 held at high voltage (identification area) |
| supply_ok | input | 1 | Supply above write threshold |
| addr | input | 11 | Byte address |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data toward the bus |
| dout_oe | output | 1 | Drive enable for `dout` |
| busy | output | 1 | Self-timed write or clear in progress |

## Verification
A read that lands inside a self-timed write or a chip-clear fill collides two functions: the array lookup and the completion poll. The bench opens a read strobe on an unrelated address while `busy` is high. It expects the inverted-bit-7 pattern of the byte being written, or 0x7F during a fill, rather than the stored byte. A second collision is a new write strobe arriving during `ST_PROG`. The bench issues one and later reads both addresses: the first must hold its new byte and the second its old one.

// File: rtl/eeprom_emu_pkg.sv
package eeprom_emu_pkg;

    typedef enum logic [2:0] {
        ST_LOCK,
        ST_IDLE,
        ST_STROBE,
        ST_PROG,
        ST_CLR_PULSE,
        ST_CLR_SWEEP
    } ctrl_state_t;

    function automatic int max_of3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/eeprom_pin_sync.sv
module eeprom_pin_sync #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              oe_hv,
    input  logic              a9_hv,
    input  logic              supply_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [ADDR_W-1:0] p_addr,
    output logic [DATA_W-1:0] p_din,
    output logic              p_a9_hv,
    output logic              p_supply,
    output logic              wr_lvl,
    output logic              wr_rise,
    output logic              wr_fall,
    output logic              wr_end_ok,
    output logic              clr_lvl,
    output logic              clr_rise,
    output logic              rd_en
);

    logic p_ce_n, p_oe_n, p_we_n, p_oe_hv;
    logic wr_q, clr_q;

    // Pin sampling stage; pins come back to the inactive level in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_ce_n   <= 1'b1;
            p_oe_n   <= 1'b1;
            p_we_n   <= 1'b1;
            p_oe_hv  <= 1'b0;
            p_a9_hv  <= 1'b0;
            p_supply <= 1'b0;
            p_addr   <= '0;
            p_din    <= '0;
            wr_q     <= 1'b0;
            clr_q    <= 1'b0;
        end else begin
            p_ce_n   <= ce_n;
            p_oe_n   <= oe_n;
            p_we_n   <= we_n;
            p_oe_hv  <= oe_hv;
            p_a9_hv  <= a9_hv;
            p_supply <= supply_ok;
            p_addr   <= addr;
            p_din    <= din;
            wr_q     <= wr_lvl;
            clr_q    <= clr_lvl;
        end
    end

    always_comb begin
        wr_lvl    = !p_ce_n && !p_we_n && p_oe_n && !p_oe_hv;
        clr_lvl   = !p_ce_n && !p_we_n && p_oe_hv;
        rd_en     = !p_ce_n && !p_oe_n && p_we_n && !p_oe_hv;
        wr_rise   = wr_lvl && !wr_q;
        wr_fall   = !wr_lvl && wr_q;
        // A strobe counts only when chip-enable or write-enable closed it.
        wr_end_ok = wr_fall && p_oe_n && !p_oe_hv;
        clr_rise  = clr_lvl && !clr_q;
    end

    // R6: output-enable low never lets a write strobe open
    assert_oe_low_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !p_oe_n |-> !wr_lvl);

endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
    import eeprom_emu_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int ID_W      = 5,
    parameter int WRITE_CYC = 40000,
    parameter int POR_CYC   = 1000000,
    parameter int CLEAR_CYC = 2000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p_supply,
    input  logic [ADDR_W-1:0] p_addr,
    input  logic [DATA_W-1:0] p_din,
    input  logic              p_a9_hv,
    input  logic              wr_lvl,
    input  logic              wr_rise,
    input  logic              wr_fall,
    input  logic              wr_end_ok,
    input  logic              clr_lvl,
    input  logic              clr_rise,
    output logic              mem_we,
    output logic              id_we,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic [DATA_W-1:0] poll_data
);

    localparam int MAX_CYC = max_of3(WRITE_CYC, POR_CYC, CLEAR_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0]  WR_LAST  = CNT_W'(WRITE_CYC - 1);
    localparam logic [CNT_W-1:0]  POR_LAST = CNT_W'(POR_CYC - 1);
    localparam logic [CNT_W-1:0]  CLR_MIN  = CNT_W'(CLEAR_CYC);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    ctrl_state_t       state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] sweep;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data;
    logic              lat_id;
    logic              commit;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOCK;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOCK:      if (cnt == POR_LAST) state_nx = ST_IDLE;
            ST_IDLE: begin
                if (wr_rise)       state_nx = ST_STROBE;
                else if (clr_rise) state_nx = ST_CLR_PULSE;
            end
            ST_STROBE:    if (wr_fall) state_nx = wr_end_ok ? ST_PROG : ST_IDLE;
            ST_PROG:      if (cnt == WR_LAST) state_nx = ST_IDLE;
            ST_CLR_PULSE: if (!clr_lvl) state_nx = (cnt >= CLR_MIN) ? ST_CLR_SWEEP : ST_IDLE;
            ST_CLR_SWEEP: if (sweep == LAST_ADDR) state_nx = ST_IDLE;
            default:      state_nx = ST_LOCK;
        endcase
        if (!p_supply) state_nx = ST_LOCK;
    end

    // Timers and latched write operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            sweep    <= '0;
            lat_addr <= '0;
            lat_data <= '0;
            lat_id   <= 1'b0;
        end else begin
            if (!p_supply || state_nx != state) begin
                cnt <= (state_nx == ST_CLR_PULSE) ? CNT_W'(1) : '0;
            end else if (state == ST_LOCK || state == ST_PROG) begin
                cnt <= cnt + 1'b1;
            end else if (state == ST_CLR_PULSE && clr_lvl && cnt < CLR_MIN) begin
                cnt <= cnt + 1'b1;
            end

            if (state == ST_CLR_SWEEP) sweep <= sweep + 1'b1;
            else                       sweep <= '0;

            if (state == ST_IDLE && wr_rise) begin
                lat_addr <= p_addr;
                lat_id   <= p_a9_hv && (&p_addr[ADDR_W-1:ID_W]);
                lat_data <= p_din;
            end else if (state == ST_STROBE && wr_lvl) begin
                lat_data <= p_din;
            end
        end
    end

    // Outputs
    always_comb begin
        mem_we    = 1'b0;
        id_we     = 1'b0;
        busy      = 1'b0;
        wr_addr   = lat_addr;
        wr_data   = lat_data;
        poll_data = {~lat_data[DATA_W-1], lat_data[DATA_W-2:0]};
        commit    = (cnt == WR_LAST) && p_supply;
        unique case (state)
            ST_PROG: begin
                busy   = 1'b1;
                mem_we = commit && !lat_id;
                id_we  = commit && lat_id;
            end
            ST_CLR_SWEEP: begin
                busy      = 1'b1;
                mem_we    = p_supply;
                wr_addr   = sweep;
                wr_data   = '1;
                poll_data = {1'b0, {(DATA_W-1){1'b1}}};
            end
            default: ;
        endcase
    end

    assert_prog_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PROG |-> cnt <= WR_LAST);

    assert_prog_not_restarted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && wr_rise) |=> (state != ST_STROBE) && $stable(lat_addr));

    assert_supply_low_locks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !p_supply |=> state == ST_LOCK);

    assert_lock_no_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_LOCK |-> !mem_we && !id_we && !busy);

    assert_clear_needs_long_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLR_PULSE && state_nx == ST_CLR_SWEEP) |-> cnt >= CLR_MIN);

endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int ID_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_we,
    input  logic              id_we,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_a9_hv,
    input  logic              rd_en,
    input  logic              busy,
    input  logic [DATA_W-1:0] poll_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);

    localparam int DEPTH    = 1 << ADDR_W;
    localparam int ID_DEPTH = 1 << ID_W;

    logic [DATA_W-1:0] main_mem [DEPTH];
    logic [DATA_W-1:0] id_mem   [ID_DEPTH];
    logic [DATA_W-1:0] main_q, id_q, poll_q;
    logic              oe_q, sel_id_q, busy_q;

    always_ff @(posedge clk) begin
        if (mem_we) main_mem[wr_addr] <= wr_data;
        if (id_we)  id_mem[wr_addr[ID_W-1:0]] <= wr_data;
        main_q <= main_mem[rd_addr];
        id_q   <= id_mem[rd_addr[ID_W-1:0]];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q     <= 1'b0;
            sel_id_q <= 1'b0;
            busy_q   <= 1'b0;
            poll_q   <= '0;
        end else begin
            oe_q     <= rd_en;
            sel_id_q <= rd_a9_hv && (&rd_addr[ADDR_W-1:ID_W]);
            busy_q   <= busy;
            poll_q   <= poll_data;
        end
    end

    always_comb begin
        if (!oe_q)         dout = '0;
        else if (busy_q)   dout = poll_q;
        else if (sel_id_q) dout = id_q;
        else               dout = main_q;
    end

    assert_single_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, id_we}));

    assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> dout == '0);

    assign dout_oe = oe_q;

endmodule

// File: rtl/eeprom_emu.sv
module eeprom_emu #(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int ID_W      = 5,
    parameter int WRITE_CYC = 40000,
    parameter int POR_CYC   = 1000000,
    parameter int CLEAR_CYC = 2000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              oe_hv,
    input  logic              a9_hv,
    input  logic              supply_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              busy
);

    logic [ADDR_W-1:0] p_addr, wr_addr;
    logic [DATA_W-1:0] p_din, wr_data, poll_data;
    logic p_a9_hv, p_supply, wr_lvl, wr_rise, wr_fall, wr_end_ok;
    logic clr_lvl, clr_rise, rd_en, mem_we, id_we;

    eeprom_pin_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk, .rst_n, .ce_n, .oe_n, .we_n, .oe_hv, .a9_hv, .supply_ok,
        .addr, .din, .p_addr, .p_din, .p_a9_hv, .p_supply,
        .wr_lvl, .wr_rise, .wr_fall, .wr_end_ok, .clr_lvl, .clr_rise, .rd_en
    );

    eeprom_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W),
        .WRITE_CYC(WRITE_CYC), .POR_CYC(POR_CYC), .CLEAR_CYC(CLEAR_CYC)
    ) u_ctrl (
        .clk, .rst_n, .p_supply, .p_addr, .p_din, .p_a9_hv,
        .wr_lvl, .wr_rise, .wr_fall, .wr_end_ok, .clr_lvl, .clr_rise,
        .mem_we, .id_we, .wr_addr, .wr_data, .busy, .poll_data
    );

    eeprom_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_store (
        .clk, .rst_n, .mem_we, .id_we, .wr_addr, .wr_data,
        .rd_addr(p_addr), .rd_a9_hv(p_a9_hv), .rd_en, .busy, .poll_data,
        .dout, .dout_oe
    );

    assert_read_decode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> $past(!ce_n && !oe_n && we_n && !oe_hv, 2));

endmodule

// File: tb/eeprom_emu_test.sv
`timescale 1ns/1ps
module eeprom_emu_test;

    localparam int WCYC = 20;
    localparam int PCYC = 30;
    localparam int CCYC = 25;

    typedef struct packed {
        logic [10:0] a;
        logic [7:0]  d;
        logic        hv;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{a: 11'h000, d: 8'hA5, hv: 1'b0},
        '{a: 11'h7FF, d: 8'h3C, hv: 1'b0},
        '{a: 11'h155, d: 8'h81, hv: 1'b0},
        '{a: 11'h2AA, d: 8'h00, hv: 1'b0},
        '{a: 11'h7E3, d: 8'h5A, hv: 1'b0},
        '{a: 11'h7E3, d: 8'hC7, hv: 1'b1},
        '{a: 11'h7E0, d: 8'h11, hv: 1'b1},
        '{a: 11'h400, d: 8'hFE, hv: 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, oe_hv = 1'b0, a9_hv = 1'b0;
    logic supply_ok = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_oe, busy;

    int n_run = 0, n_fail = 0;
    logic [7:0] rv;
    logic       roe;

    always #2.5 clk = ~clk;

    eeprom_emu #(.WRITE_CYC(WCYC), .POR_CYC(PCYC), .CLEAR_CYC(CCYC)) uut (
        .clk, .rst_n, .ce_n, .oe_n, .we_n, .oe_hv, .a9_hv, .supply_ok,
        .addr, .din, .dout, .dout_oe, .busy
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [10:0] a, input logic [7:0] d, input logic hv);
        addr = a; din = d; a9_hv = hv; oe_n = 1'b1; oe_hv = 1'b0; we_n = 1'b1; ce_n = 1'b0;
        tick(2);
        we_n = 1'b0;
        tick(2);
        addr = ~a; din = 8'hEE;      // address changes after strobe opens (R2)
        tick(2);
        din = d;                     // last data while open counts (R2)
        tick(2);
        we_n = 1'b1;
        tick(1);
        ce_n = 1'b1; a9_hv = 1'b0;
    endtask

    task automatic do_read(input logic [10:0] a, input logic hv);
        addr = a; a9_hv = hv; we_n = 1'b1; oe_hv = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
        tick(3);
        rv = dout; roe = dout_oe;
        ce_n = 1'b1; oe_n = 1'b1; a9_hv = 1'b0;
        tick(1);
    endtask

    task automatic wait_busy();
        for (int i = 0; i < 50 && !busy; i++) tick(1);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) tick(1);
    endtask

    task automatic clear_pulse(input int n);
        ce_n = 1'b0; oe_n = 1'b1; oe_hv = 1'b1; we_n = 1'b1;
        tick(2);
        we_n = 1'b0;
        tick(n);
        we_n = 1'b1;
        tick(1);
        ce_n = 1'b1; oe_hv = 1'b0;
        tick(2);
    endtask

    initial begin
        int cnt;
        tick(4);
        rst_n = 1'b1;
        tick(1);
        chk("R10 oe after reset", dout_oe, 0);
        chk("R10 busy after reset", busy, 0);
        tick(PCYC + 10);

        // Vector table: write all, then read all back
        foreach (VECS[i]) begin
            do_write(VECS[i].a, VECS[i].d, VECS[i].hv);
            wait_busy();
            wait_idle();
        end
        foreach (VECS[i]) begin
            do_read(VECS[i].a, VECS[i].hv);
            chk("R1 read enable", roe, 1);
            chk(VECS[i].hv ? "R9 id readback" : "R2 readback", rv, VECS[i].d);
        end

        // R1: no drive with we low or ce high
        addr = 11'h000; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; tick(3);
        chk("R1 we low no drive", dout_oe, 0);
        chk("R1 dout zero", dout, 0);
        ce_n = 1'b1; we_n = 1'b1; tick(3);
        chk("R1 ce high no drive", dout_oe, 0);
        oe_n = 1'b1; tick(1);

        // R4 polling on another address, then true data
        do_write(11'h000, 8'h37, 1'b0);
        wait_busy();
        do_read(11'h155, 1'b0);
        chk("R4 poll bit7 inverted", rv, 8'hB7);
        wait_idle();
        do_read(11'h000, 1'b0);
        chk("R4 true data after", rv, 8'h37);

        // R3 exact busy length
        do_write(11'h400, 8'hC4, 1'b0);
        wait_busy();
        cnt = 0;
        while (busy && cnt < 1000) begin cnt++; tick(1); end
        chk("R3 busy cycles", cnt, WCYC);
        do_read(11'h400, 1'b0);
        chk("R3 stored", rv, 8'hC4);

        // R5 strobe during busy ignored
        do_write(11'h155, 8'h42, 1'b0);
        wait_busy();
        do_write(11'h2AA, 8'h99, 1'b0);
        wait_idle();
        tick(WCYC + 5);
        chk("R5 no second busy", busy, 0);
        do_read(11'h155, 1'b0);
        chk("R5 first write kept", rv, 8'h42);
        do_read(11'h2AA, 1'b0);
        chk("R5 second write ignored", rv, 8'h00);

        // R6 output-enable low ends the strobe
        addr = 11'h7FF; din = 8'h55; ce_n = 1'b0; oe_n = 1'b1; tick(2);
        we_n = 1'b0; tick(3);
        oe_n = 1'b0; tick(2);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1; tick(3);
        chk("R6 abort no busy", busy, 0);
        do_read(11'h7FF, 1'b0);
        chk("R6 abort no store", rv, 8'h3C);

        // R7 supply lockout
        supply_ok = 1'b0; tick(3);
        do_write(11'h000, 8'h99, 1'b0);
        tick(3);
        chk("R7 supply low no busy", busy, 0);
        supply_ok = 1'b1;
        do_write(11'h000, 8'h98, 1'b0);
        tick(2);
        chk("R7 power-on hold no busy", busy, 0);
        do_read(11'h000, 1'b0);
        chk("R7 read in lockout", rv, 8'h37);
        tick(PCYC + 5);
        do_write(11'h000, 8'h66, 1'b0);
        wait_busy(); wait_idle();
        do_read(11'h000, 1'b0);
        chk("R7 write after hold", rv, 8'h66);

        // R8 chip clear: short pulse, then long pulse
        clear_pulse(CCYC / 2);
        chk("R8 short pulse no busy", busy, 0);
        do_read(11'h155, 1'b0);
        chk("R8 short pulse no clear", rv, 8'h42);
        clear_pulse(CCYC + 5);
        chk("R8 fill busy", busy, 1);
        do_read(11'h2AA, 1'b0);
        chk("R8 poll during fill", rv, 8'h7F);
        wait_idle();
        do_read(11'h000, 1'b0);
        chk("R8 cleared 000", rv, 8'hFF);
        do_read(11'h155, 1'b0);
        chk("R8 cleared 155", rv, 8'hFF);
        do_read(11'h7E3, 1'b0);
        chk("R9 main 7E3 cleared", rv, 8'hFF);
        do_read(11'h7E3, 1'b1);
        chk("R9 id kept after clear", rv, 8'hC7);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule